// File: doc/BRIEF.md
# Multi-Lane Sequence Number Allocator

This block hands out instruction sequence numbers from a circular pool of 2^SEQ_BITS entries. Every cycle a fetch stage presents one request bit per lane. If the pool can serve every requesting lane, each of those lanes is granted one number. The numbers run in lane order and start at the head pointer, and lanes that did not request are skipped. If the pool cannot serve every requesting lane, no lane is granted anything.

Retirement reports numbers through a set of commit ports, and each reported number is marked free in a per-entry busy map. The tail pointer only moves forward in order. It steps over free entries at the oldest end of the pool, at most RECLAIM_W entries per cycle, and it stops at the first entry that is still busy.

A control-flow redirect carries the sequence number S of the redirecting instruction. It frees every number allocated after S and rewinds the head to S+1. Any allocation in the same cycle starts from that rewound head. Both pointers carry an extra wrap bit, so a full pool can be told apart from an empty one. The age test for a redirect measures distance from the tail, which keeps it correct after the numbers wrap.

Top module: `seq_num_alloc`

## Requirements
- R1: After reset the tail reads 0, the pool is empty, and the first granted number is 0.
- R2: Lane k, when granted, receives head + (number of requesting lanes below k). A lane whose request bit is low gets no grant.
- R3: The request is granted to all requesting lanes or to none. It is granted only when the count of requesting lanes does not exceed the free count, where the free count is the pool size minus (head − tail) after any same-cycle redirect.
- R4: A committed number is marked free at the next edge. The tail never steps past a number that is still busy, even when younger numbers are already free.
- R5: The tail advances by at most RECLAIM_W (default 2) entries per cycle. Busy-map state is read as of the start of the cycle, so a commit can let the tail move over that number no earlier than the following edge.
- R6: A redirect with number S sets the head to S+1 and frees every number between S+1 and the old head. S itself stays busy.
- R7: An allocation in the same cycle as a redirect starts at S+1.
- R8: Numbers wrap modulo 2^SEQ_BITS. With 2^SEQ_BITS numbers outstanding the pool is full and grants nothing. With 0 outstanding it is empty and can grant.
- R9: "Younger than S" is measured as distance from the tail, so a redirect whose S is numerically below the tail index after a wrap still rewinds correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_req_i | input | LANES | Per-lane allocation request |
| alloc_gnt_o | output | LANES | Per-lane grant (all or none) |
| alloc_seq_o | output | LANES*SEQ_BITS | Granted number per lane, lane 0 in the low bits |
| commit_val_i | input | COMMIT_W | Commit port valid bits |
| commit_seq_i | input | COMMIT_W*SEQ_BITS | Committed number per port |
| redir_val_i | input | 1 | Control-flow redirect |
| redir_seq_i | input | SEQ_BITS | Number of the redirecting instruction |
| tail_o | output | SEQ_BITS | Oldest outstanding number |

## Verification
The bench commits numbers out of order and checks that the tail waits at the oldest busy entry. A design that freed entries by count instead of by identity would move the tail too early. It fills the pool across the wrap point to check that the full state refuses even a single-lane request. A design without the wrap bit would treat a full pool as empty and hand out live numbers again. It issues a redirect in the same cycle as a request, and a design that used the stale head would grant numbers past the squashed range. It also issues a redirect whose S is numerically below the tail index, where a raw numeric age compare frees the wrong entries and gets the free count wrong.

// File: rtl/seq_alloc_pkg.sv
package seq_alloc_pkg;
  localparam int unsigned SEQ_BITS_DEF  = 4;
  localparam int unsigned LANES_DEF     = 4;
  localparam int unsigned RECLAIM_W_DEF = 2;
  localparam int unsigned COMMIT_W_DEF  = 2;

  function automatic int unsigned ones(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += 32'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/seq_lane_grant.sv
module seq_lane_grant
  import seq_alloc_pkg::*;
#(
  parameter int unsigned SEQ_BITS = SEQ_BITS_DEF,
  parameter int unsigned LANES    = LANES_DEF,
  localparam int unsigned PTR_W   = SEQ_BITS + 1,
  localparam int unsigned CNT_W   = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]          req_i,
  input  logic [SEQ_BITS-1:0]       head_i,
  input  logic [PTR_W-1:0]          free_i,
  output logic [LANES-1:0]          gnt_o,
  output logic [LANES*SEQ_BITS-1:0] seq_o,
  output logic [CNT_W-1:0]          n_gnt_o
);
  logic [CNT_W-1:0] n_req;
  logic             fits;

  always_comb begin
    n_req = CNT_W'(ones(32'(req_i), LANES));
    fits  = 32'(n_req) <= 32'(free_i);
    gnt_o   = fits ? req_i : '0;
    n_gnt_o = fits ? n_req : '0;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CNT_W-1:0] pre;
    if (k == 0) begin : g_first
      assign pre = '0;
    end else begin : g_rest
      assign pre = CNT_W'(ones(32'(req_i[k-1:0]), k));
    end
    assign seq_o[k*SEQ_BITS +: SEQ_BITS] = head_i + SEQ_BITS'(pre);
  end

  always_comb begin
    if ((gnt_o & ~req_i) != '0) $error("p_mask_r2: grant on idle lane");
    if (gnt_o != '0 && gnt_o != req_i) $error("p_all_or_none_r3: partial grant");
  end
endmodule

// File: rtl/seq_reclaim.sv
module seq_reclaim
  import seq_alloc_pkg::*;
#(
  parameter int unsigned SEQ_BITS  = SEQ_BITS_DEF,
  parameter int unsigned RECLAIM_W = RECLAIM_W_DEF,
  localparam int unsigned POOL     = 1 << SEQ_BITS,
  localparam int unsigned PTR_W    = SEQ_BITS + 1
) (
  input  logic [POOL-1:0]     busy_i,
  input  logic [SEQ_BITS-1:0] tail_i,
  input  logic [PTR_W-1:0]    occ_i,
  output logic [PTR_W-1:0]    adv_o
);
  always_comb begin
    logic stop;
    logic [SEQ_BITS-1:0] idx;
    stop  = 1'b0;
    adv_o = '0;
    for (int unsigned j = 0; j < RECLAIM_W; j++) begin
      idx = tail_i + SEQ_BITS'(j);
      if (!stop && 32'(j) < 32'(occ_i) && !busy_i[idx]) adv_o = PTR_W'(j + 1);
      else stop = 1'b1;
    end
  end
endmodule

// File: rtl/seq_busy_map.sv
module seq_busy_map
  import seq_alloc_pkg::*;
#(
  parameter int unsigned SEQ_BITS = SEQ_BITS_DEF,
  parameter int unsigned LANES    = LANES_DEF,
  parameter int unsigned COMMIT_W = COMMIT_W_DEF,
  localparam int unsigned POOL    = 1 << SEQ_BITS,
  localparam int unsigned PTR_W   = SEQ_BITS + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             gnt_i,
  input  logic [LANES*SEQ_BITS-1:0]    seq_i,
  input  logic [COMMIT_W-1:0]          cval_i,
  input  logic [COMMIT_W*SEQ_BITS-1:0] cseq_i,
  input  logic                         sq_i,
  input  logic [SEQ_BITS-1:0]          sq_dist_i,
  input  logic [SEQ_BITS-1:0]          tail_i,
  input  logic [PTR_W-1:0]             occ_i,
  output logic [POOL-1:0]              busy_o
);
  logic [POOL-1:0] busy_q, busy_d;

  always_comb begin
    logic [SEQ_BITS-1:0] d;
    busy_d = busy_q;
    // squash: entries strictly younger than S and below the old head
    for (int unsigned i = 0; i < POOL; i++) begin
      d = SEQ_BITS'(i) - tail_i;
      if (sq_i && d > sq_dist_i && {1'b0, d} < occ_i) busy_d[i] = 1'b0;
    end
    for (int unsigned c = 0; c < COMMIT_W; c++)
      if (cval_i[c]) busy_d[cseq_i[c*SEQ_BITS +: SEQ_BITS]] = 1'b0;
    for (int unsigned k = 0; k < LANES; k++)
      if (gnt_i[k]) busy_d[seq_i[k*SEQ_BITS +: SEQ_BITS]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;

  assign busy_o = busy_q;

  p_commit_frees_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cval_i[0] && !gnt_i[0] && !gnt_i[LANES-1]) |=> !busy_q[$past(cseq_i[SEQ_BITS-1:0])]);
endmodule

// File: rtl/seq_num_alloc.sv
module seq_num_alloc
  import seq_alloc_pkg::*;
#(
  parameter int unsigned SEQ_BITS  = SEQ_BITS_DEF,
  parameter int unsigned LANES     = LANES_DEF,
  parameter int unsigned RECLAIM_W = RECLAIM_W_DEF,
  parameter int unsigned COMMIT_W  = COMMIT_W_DEF
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             alloc_req_i,
  output logic [LANES-1:0]             alloc_gnt_o,
  output logic [LANES*SEQ_BITS-1:0]    alloc_seq_o,
  input  logic [COMMIT_W-1:0]          commit_val_i,
  input  logic [COMMIT_W*SEQ_BITS-1:0] commit_seq_i,
  input  logic                         redir_val_i,
  input  logic [SEQ_BITS-1:0]          redir_seq_i,
  output logic [SEQ_BITS-1:0]          tail_o
);
  localparam int unsigned POOL  = 1 << SEQ_BITS;
  localparam int unsigned PTR_W = SEQ_BITS + 1;
  localparam int unsigned CNT_W = $clog2(LANES + 1);

  logic [PTR_W-1:0]    head_q, tail_q, head_post;
  logic [PTR_W-1:0]    occ_pre, occ_post, free_cnt, adv;
  logic [SEQ_BITS-1:0] sq_dist;
  logic [CNT_W-1:0]    n_gnt;
  logic [POOL-1:0]     busy;

  always_comb begin
    occ_pre   = head_q - tail_q;
    sq_dist   = redir_seq_i - tail_q[SEQ_BITS-1:0];
    head_post = redir_val_i ? tail_q + PTR_W'(sq_dist) + PTR_W'(1) : head_q;
    occ_post  = head_post - tail_q;
    free_cnt  = PTR_W'(POOL) - occ_post;
  end

  seq_lane_grant #(.SEQ_BITS(SEQ_BITS), .LANES(LANES)) u_grant (
    .req_i   (alloc_req_i),
    .head_i  (head_post[SEQ_BITS-1:0]),
    .free_i  (free_cnt),
    .gnt_o   (alloc_gnt_o),
    .seq_o   (alloc_seq_o),
    .n_gnt_o (n_gnt)
  );

  seq_busy_map #(.SEQ_BITS(SEQ_BITS), .LANES(LANES), .COMMIT_W(COMMIT_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gnt_i     (alloc_gnt_o),
    .seq_i     (alloc_seq_o),
    .cval_i    (commit_val_i),
    .cseq_i    (commit_seq_i),
    .sq_i      (redir_val_i),
    .sq_dist_i (sq_dist),
    .tail_i    (tail_q[SEQ_BITS-1:0]),
    .occ_i     (occ_pre),
    .busy_o    (busy)
  );

  seq_reclaim #(.SEQ_BITS(SEQ_BITS), .RECLAIM_W(RECLAIM_W)) u_reclaim (
    .busy_i (busy),
    .tail_i (tail_q[SEQ_BITS-1:0]),
    .occ_i  (occ_post),
    .adv_o  (adv)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_post + PTR_W'(n_gnt);
      tail_q <= tail_q + adv;
    end

  assign tail_o = tail_q[SEQ_BITS-1:0];

  p_occ_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_q - tail_q) <= PTR_W'(POOL));
  p_tail_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tail_q - $past(tail_q)) <= PTR_W'(RECLAIM_W));
  p_redir_head_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_val_i |=> head_q[SEQ_BITS-1:0] ==
      SEQ_BITS'($past(redir_seq_i) + SEQ_BITS'(1) + SEQ_BITS'($past(n_gnt))));
  p_no_gnt_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redir_val_i && (head_q - tail_q) == PTR_W'(POOL)) |-> alloc_gnt_o == '0);
endmodule

// File: tb/sim_seq_num_alloc.sv
module sim_seq_num_alloc;
  localparam int N = 4, L = 4, C = 2;

  logic clk = 0, rst_ni = 0;
  logic [L-1:0]   req = '0;
  logic [L-1:0]   gnt;
  logic [L*N-1:0] seqs;
  logic [C-1:0]   cv = '0;
  logic [C*N-1:0] cs = '0;
  logic           rv = 0;
  logic [N-1:0]   rs = '0;
  logic [N-1:0]   tail;

  always #4 clk = ~clk;

  seq_num_alloc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_req_i(req), .alloc_gnt_o(gnt),
    .alloc_seq_o(seqs), .commit_val_i(cv), .commit_seq_i(cs),
    .redir_val_i(rv), .redir_seq_i(rs), .tail_o(tail));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  // req, cv, cs0, cs1, rv, rs, egnt, eseq, etail
  typedef struct packed {
    logic [3:0] req; logic [1:0] cv; logic [3:0] cs0; logic [3:0] cs1;
    logic rv; logic [3:0] rs; logic [3:0] egnt; logic [3:0] eseq; logic [3:0] etail;
  } row_t;
  localparam row_t TBL [10] = '{
    '{4'hF, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0, 4'hF, 4'd0, 4'd0},
    '{4'h5, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0, 4'h5, 4'd4, 4'd0},
    '{4'h0, 2'd3, 4'd1, 4'd2, 1'b0, 4'd0, 4'h0, 4'd0, 4'd0},
    '{4'h0, 2'd1, 4'd0, 4'd0, 1'b0, 4'd0, 4'h0, 4'd0, 4'd0},
    '{4'h0, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0, 4'h0, 4'd0, 4'd2},
    '{4'h0, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0, 4'h0, 4'd0, 4'd3},
    '{4'h3, 2'd0, 4'd0, 4'd0, 1'b1, 4'd3, 4'h3, 4'd4, 4'd3},
    '{4'h0, 2'd0, 4'd0, 4'd0, 1'b1, 4'd4, 4'h0, 4'd0, 4'd3},
    '{4'h0, 2'd3, 4'd3, 4'd4, 1'b0, 4'd0, 4'h0, 4'd0, 4'd3},
    '{4'h0, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0, 4'h0, 4'd0, 4'd5}
  };

  // drive at negedge, check grants, then check tail after the edge
  task automatic step(logic [L-1:0] r, logic [C-1:0] v, logic [N-1:0] c0, logic [N-1:0] c1,
                      logic rvv, logic [N-1:0] rss, logic [L-1:0] eg, int es, int et, string tag);
    int p;
    @(negedge clk);
    req = r; cv = v; cs = {c1, c0}; rv = rvv; rs = rss;
    #1;
    chk({tag, " R3 grant"}, int'(gnt), int'(eg));
    p = 0;
    for (int k = 0; k < L; k++) begin
      if (eg[k]) begin
        chk({tag, " R2 lane seq"}, int'(seqs[k*N +: N]), (es + p) % 16);
        p++;
      end
    end
    @(posedge clk); #1;
    req = '0; cv = '0; rv = 0;
    if (et >= 0) chk({tag, " R5 tail"}, int'(tail), et);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20;
    chk("R1 reset tail", int'(tail), 0);
    @(negedge clk); rst_ni = 1;
    // table: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < 10; i++)
      step(TBL[i].req, TBL[i].cv, TBL[i].cs0, TBL[i].cs1, TBL[i].rv, TBL[i].rs,
           TBL[i].egnt, int'(TBL[i].eseq), int'(TBL[i].etail), $sformatf("row%0d", i));
    // R8: fill all 16 across the wrap, head starts at 5
    step(4'hF, 0, 0, 0, 0, 0, 4'hF, 5, 5, "R8 fill0");
    step(4'hF, 0, 0, 0, 0, 0, 4'hF, 9, 5, "R8 fill1");
    step(4'hF, 0, 0, 0, 0, 0, 4'hF, 13, 5, "R8 fill2");
    step(4'hF, 0, 0, 0, 0, 0, 4'hF, 1, 5, "R8 fill3");
    step(4'h1, 0, 0, 0, 0, 0, 4'h0, 0, 5, "R8 full");
    // R4: commit 6 before 5, tail waits
    step(4'h0, 2'b01, 6, 0, 0, 0, 4'h0, 0, 5, "R4 young");
    step(4'h0, 0, 0, 0, 0, 0, 4'h0, 0, 5, "R4 wait");
    step(4'h0, 2'b01, 5, 0, 0, 0, 4'h0, 0, 5, "R4 old");
    step(4'h0, 0, 0, 0, 0, 0, 4'h0, 0, 7, "R4 move");
    step(4'hF, 0, 0, 0, 0, 0, 4'h0, 0, 7, "R3 short");
    step(4'h3, 0, 0, 0, 0, 0, 4'h3, 5, 7, "R8 rewrap");
    // R9: redirect to 2 (below tail 7) with same-cycle request, R7
    step(4'h1, 0, 0, 0, 1, 2, 4'h1, 3, 7, "R9 redir");
    step(4'hF, 0, 0, 0, 0, 0, 4'h0, 0, 7, "R9 free3");
    step(4'h7, 0, 0, 0, 0, 0, 4'h7, 4, 7, "R9 take3");
    step(4'h1, 0, 0, 0, 0, 0, 4'h0, 0, 7, "R9 full");
    // R1: reset mid-run
    @(negedge clk); rst_ni = 0; #2;
    chk("R1 tail after reset", int'(tail), 0);
    @(negedge clk); rst_ni = 1;
    step(4'h2, 0, 0, 0, 0, 0, 4'h2, 0, 0, "R1 first");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule